// File: doc/BRIEF.md
# Prioritised Task Dispatcher

This block chooses which of eight tasks a single-thread coprocessor runs next, and when it runs it. Each task has a hardware trigger. A per-task configuration bit picks that trigger from one of two interrupt sources. The host can also raise requests from software and clear flags through write strobes. A request marks its task as pending. When the coprocessor is idle, the dispatcher takes the lowest-numbered task that is both pending and enabled. It hands over that task's 12-bit start offset with a one-cycle start strobe, and it marks the task as running until the execution core returns a stop strobe.

A task that has started always runs to completion. If a hardware request arrives while the same task is still pending, the block records an overflow. Requests raised by software never record an overflow. On each stop the block raises a one-cycle completion interrupt on that task's own line.

Top module: `task_dispatch_ctrl`

## Requirements
- R1: Among tasks that are pending and enabled, the one with the lowest index is dispatched first. Index 0 is task 1 and has the highest priority.
- R2: `src_sel[i]` chooses the hardware trigger of task i. A value of 0 selects `conv_irq[i]`. A value of 1 selects `pwm_irq[i]` for i below 7, and `tmr0_irq` for i = 7. A pulse on the source that is not selected has no effect.
- R3: A selected hardware pulse sets `pend_flags[i]` one cycle later. If `pend_flags[i]` is already set and the task is not being dispatched in that cycle, the pulse sets `ovf_flags[i]` instead, and the pending bit stays set.
- R4: A write strobe `sw_force_we` sets `pend_flags` wherever `host_wdata` has a 1 (bit i is task i). It never sets an overflow flag, even when the task is already pending.
- R5: Dispatch happens in a cycle where `run_map` is zero and some task is pending and enabled. At the next edge the block clears that task's pending bit, sets its `run_map` bit and gives `start_stb` for one cycle. At the same time `start_pc` is loaded with `vec_table[12*i +: 12]`. From a hardware pulse to `start_stb` is two cycles.
- R6: At most one `run_map` bit is set. While a task runs, new requests of any priority only become pending. `run_map` does not change until a stop arrives.
- R7: When `core_stop` arrives during a run, the running bit clears at the next edge. `done_irq` then pulses for one cycle on that task's bit. The next dispatch is decided in that same cycle, so the next `start_stb` comes one cycle after `done_irq`.
- R8: `sw_clr_pend_we` clears the pending bits and `sw_clr_ovf_we` clears the overflow bits where `host_wdata` has a 1. If a hardware set hits the same bit in the same cycle, the set wins.
- R9: A disabled task (`task_en[i]` = 0) keeps its pending flag and is never dispatched. It becomes eligible in the first cycle in which its enable is 1.
- R10: A synchronous reset clears pending, overflow, running and completion state, and `start_stb`.
- R11: A `core_stop` pulse while no task runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_irq | input | 8 | Converter interrupt pulses, one per task |
| pwm_irq | input | 7 | PWM interrupt pulses for tasks 1 to 7 |
| tmr0_irq | input | 1 | Timer 0 pulse, alternate source of task 8 |
| src_sel | input | 8 | Per-task trigger source select |
| task_en | input | 8 | Per-task enable mask |
| sw_force_we | input | 1 | Software force write strobe |
| sw_clr_pend_we | input | 1 | Pending-clear write strobe |
| sw_clr_ovf_we | input | 1 | Overflow-clear write strobe |
| host_wdata | input | 8 | Task bitmask for the host write strobes |
| vec_table | input | 96 | Eight 12-bit start offsets, task i at bits 12*i+11:12*i |
| core_stop | input | 1 | End-of-task strobe from the execution core |
| start_stb | output | 1 | One-cycle start strobe to the execution core |
| start_pc | output | 12 | Start program counter for the dispatched task |
| run_map | output | 8 | Bitmap of the running task |
| pend_flags | output | 8 | Pending request flags |
| ovf_flags | output | 8 | Overflow flags |
| done_irq | output | 8 | Per-task completion interrupt pulses |

## Verification
Every internal state of this block is visible at the ports, so a corrupt pending or overflow bit shows on `pend_flags` or `ovf_flags` one edge after the stimulus that caused it. A wrong priority choice or a wrong vector shows up two cycles after the request, as the wrong `run_map` bit or the wrong `start_pc` under `start_stb`. A broken run-to-completion rule appears as a second start or a changed `run_map` while a task is still running. A lost stop appears as a missing `done_irq` pulse one cycle after `core_stop`. The bench sweeps every pending pattern through the priority order, and it sweeps every task and every source choice through the set, overflow and clear paths.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

    localparam int TD_TASKS = 8;
    localparam int TD_PC_W  = 12;

    typedef enum logic {
        SRC_CONV = 1'b0,
        SRC_ALT  = 1'b1
    } src_choice_e;

    typedef enum logic {
        DSP_IDLE = 1'b0,
        DSP_BUSY = 1'b1
    } dsp_state_e;

endpackage

// File: rtl/tdisp_trig_select.sv
module tdisp_trig_select
    import tdisp_pkg::*;
#(
    parameter int NTASK = TD_TASKS
) (
    input  logic [NTASK-1:0] conv_irq,
    input  logic [NTASK-2:0] pwm_irq,
    input  logic             tmr0_irq,
    input  logic [NTASK-1:0] src_sel,
    output logic [NTASK-1:0] hw_req
);

    genvar gi;
    generate
        for (gi = 0; gi < NTASK; gi++) begin : g_sel
            logic alt_src;
            if (gi == NTASK - 1) begin : g_last
                assign alt_src = tmr0_irq;
            end else begin : g_pwm
                assign alt_src = pwm_irq[gi];
            end
            assign hw_req[gi] = (src_choice_e'(src_sel[gi]) == SRC_ALT) ? alt_src : conv_irq[gi];
        end
    endgenerate

endmodule

// File: rtl/tdisp_flag_bank.sv
module tdisp_flag_bank
    import tdisp_pkg::*;
#(
    parameter int NTASK = TD_TASKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTASK-1:0] hw_req,
    input  logic             sw_force_we,
    input  logic             sw_clr_pend_we,
    input  logic             sw_clr_ovf_we,
    input  logic [NTASK-1:0] host_wdata,
    input  logic [NTASK-1:0] disp_mask,
    output logic [NTASK-1:0] pend_q,
    output logic [NTASK-1:0] ovf_q
);

    logic [NTASK-1:0] force_set;
    logic [NTASK-1:0] pend_clr;
    logic [NTASK-1:0] ovf_clr;
    logic [NTASK-1:0] ovf_set;

    always_comb begin
        force_set = sw_force_we    ? host_wdata : '0;
        pend_clr  = sw_clr_pend_we ? host_wdata : '0;
        ovf_clr   = sw_clr_ovf_we  ? host_wdata : '0;
        // only hardware requests may overflow; a task leaving pending this cycle does not
        ovf_set   = hw_req & pend_q & ~disp_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ovf_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr & ~disp_mask) | hw_req | force_set;
            ovf_q  <= (ovf_q & ~ovf_clr) | ovf_set;
        end
    end

    AST_FORCE_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ovf_q & ~$past(ovf_q) & ~$past(hw_req)) == '0)); // R4

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hw_req != '0) |=> ((pend_q & $past(hw_req)) == $past(hw_req))); // R8

    AST_OVF_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        ((hw_req & pend_q & ~disp_mask) != '0) |=> ((ovf_q & $past(hw_req & pend_q & ~disp_mask)) != '0)); // R3

endmodule

// File: rtl/tdisp_dispatcher.sv
module tdisp_dispatcher
    import tdisp_pkg::*;
#(
    parameter int NTASK = TD_TASKS,
    parameter int PC_W  = TD_PC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTASK-1:0]      pend,
    input  logic [NTASK-1:0]      task_en,
    input  logic [NTASK*PC_W-1:0] vec_table,
    input  logic                  core_stop,
    output logic [NTASK-1:0]      disp_mask,
    output logic [NTASK-1:0]      run_q,
    output logic [NTASK-1:0]      done_q,
    output logic                  start_stb,
    output logic [PC_W-1:0]       start_pc
);

    logic [NTASK-1:0] eligible;
    logic [NTASK-1:0] pick;
    logic [PC_W-1:0]  pick_pc;
    logic             found;
    dsp_state_e       state;

    assign state    = (run_q != '0) ? DSP_BUSY : DSP_IDLE;
    assign eligible = pend & task_en;

    always_comb begin
        pick    = '0;
        pick_pc = '0;
        found   = 1'b0;
        for (int i = 0; i < NTASK; i++) begin
            if (eligible[i] && !found) begin
                pick[i] = 1'b1;
                pick_pc = vec_table[i*PC_W +: PC_W];
                found   = 1'b1;
            end
        end
    end

    assign disp_mask = (state == DSP_IDLE) ? pick : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            done_q    <= '0;
            start_stb <= 1'b0;
            start_pc  <= '0;
        end else begin
            start_stb <= 1'b0;
            done_q    <= '0;
            if (state == DSP_IDLE) begin
                if (found) begin
                    run_q     <= pick;
                    start_stb <= 1'b1;
                    start_pc  <= pick_pc;
                end
            end else if (core_stop) begin
                run_q  <= '0;
                done_q <= run_q;
            end
        end
    end

    AST_RUN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(run_q)); // R6

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        ((run_q != '0) && !core_stop) |=> $stable(run_q)); // R6

    AST_START_HAS_RUN: assert property (@(posedge clk) disable iff (rst)
        start_stb |-> ($countones(run_q) == 1)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (done_q != '0) |=> (done_q == '0)); // R7

    AST_DONE_MATCHES_RUN: assert property (@(posedge clk) disable iff (rst)
        ((run_q != '0) && core_stop) |=> ((done_q == $past(run_q)) && (run_q == '0))); // R7

endmodule

// File: rtl/task_dispatch_ctrl.sv
module task_dispatch_ctrl
    import tdisp_pkg::*;
#(
    parameter int NTASK = TD_TASKS,
    parameter int PC_W  = TD_PC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTASK-1:0]      conv_irq,
    input  logic [NTASK-2:0]      pwm_irq,
    input  logic                  tmr0_irq,
    input  logic [NTASK-1:0]      src_sel,
    input  logic [NTASK-1:0]      task_en,
    input  logic                  sw_force_we,
    input  logic                  sw_clr_pend_we,
    input  logic                  sw_clr_ovf_we,
    input  logic [NTASK-1:0]      host_wdata,
    input  logic [NTASK*PC_W-1:0] vec_table,
    input  logic                  core_stop,
    output logic                  start_stb,
    output logic [PC_W-1:0]       start_pc,
    output logic [NTASK-1:0]      run_map,
    output logic [NTASK-1:0]      pend_flags,
    output logic [NTASK-1:0]      ovf_flags,
    output logic [NTASK-1:0]      done_irq
);

    logic [NTASK-1:0] hw_req;
    logic [NTASK-1:0] disp_mask;

    tdisp_trig_select #(.NTASK(NTASK)) u_trig (
        .conv_irq (conv_irq),
        .pwm_irq  (pwm_irq),
        .tmr0_irq (tmr0_irq),
        .src_sel  (src_sel),
        .hw_req   (hw_req)
    );

    tdisp_flag_bank #(.NTASK(NTASK)) u_flags (
        .clk            (clk),
        .rst            (rst),
        .hw_req         (hw_req),
        .sw_force_we    (sw_force_we),
        .sw_clr_pend_we (sw_clr_pend_we),
        .sw_clr_ovf_we  (sw_clr_ovf_we),
        .host_wdata     (host_wdata),
        .disp_mask      (disp_mask),
        .pend_q         (pend_flags),
        .ovf_q          (ovf_flags)
    );

    tdisp_dispatcher #(.NTASK(NTASK), .PC_W(PC_W)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_flags),
        .task_en   (task_en),
        .vec_table (vec_table),
        .core_stop (core_stop),
        .disp_mask (disp_mask),
        .run_q     (run_map),
        .done_q    (done_irq),
        .start_stb (start_stb),
        .start_pc  (start_pc)
    );

    AST_IDLE_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((run_map == '0) && core_stop) |=> (done_irq == '0)); // R11

endmodule

// File: tb/task_dispatch_ctrl_bench.sv
module task_dispatch_ctrl_bench;

    localparam int N = 8;
    localparam int W = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   conv_irq = '0;
    logic [N-2:0]   pwm_irq = '0;
    logic           tmr0_irq = 1'b0;
    logic [N-1:0]   src_sel = '0;
    logic [N-1:0]   task_en = '0;
    logic           sw_force_we = 1'b0;
    logic           sw_clr_pend_we = 1'b0;
    logic           sw_clr_ovf_we = 1'b0;
    logic [N-1:0]   host_wdata = '0;
    logic [N*W-1:0] vec_table;
    logic           core_stop = 1'b0;
    logic           start_stb;
    logic [W-1:0]   start_pc;
    logic [N-1:0]   run_map, pend_flags, ovf_flags, done_irq;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    task_dispatch_ctrl u_task_dispatch_ctrl (
        .clk(clk), .rst(rst), .conv_irq(conv_irq), .pwm_irq(pwm_irq), .tmr0_irq(tmr0_irq),
        .src_sel(src_sel), .task_en(task_en), .sw_force_we(sw_force_we),
        .sw_clr_pend_we(sw_clr_pend_we), .sw_clr_ovf_we(sw_clr_ovf_we),
        .host_wdata(host_wdata), .vec_table(vec_table), .core_stop(core_stop),
        .start_stb(start_stb), .start_pc(start_pc), .run_map(run_map),
        .pend_flags(pend_flags), .ovf_flags(ovf_flags), .done_irq(done_irq)
    );

    function automatic logic [W-1:0] vexp(int i);
        return W'((i + 1) * 64 + i * 3);
    endfunction

    function automatic int lowest(logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(int t, bit alt);
        if (!alt) conv_irq[t] = 1'b1;
        else if (t == N - 1) tmr0_irq = 1'b1;
        else pwm_irq[t] = 1'b1;
        tick();
        conv_irq = '0; pwm_irq = '0; tmr0_irq = 1'b0;
    endtask

    task automatic host_write(int kind, logic [N-1:0] d);
        host_wdata = d;
        sw_force_we    = (kind == 0);
        sw_clr_pend_we = (kind == 1);
        sw_clr_ovf_we  = (kind == 2);
        tick();
        sw_force_we = 1'b0; sw_clr_pend_we = 1'b0; sw_clr_ovf_we = 1'b0;
    endtask

    task automatic stop_task();
        core_stop = 1'b1;
        tick();
        core_stop = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) vec_table[i*W +: W] = vexp(i);
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        // R10 reset state
        check("R10 pend", 32'(pend_flags), 0);
        check("R10 ovf", 32'(ovf_flags), 0);
        check("R10 run", 32'(run_map), 0);
        check("R10 stb", 32'(start_stb), 0);
        check("R10 done", 32'(done_irq), 0);

        // R2 / R3 / R8: every task, both source choices
        for (int t = 0; t < N; t++) begin
            for (int s = 0; s < 2; s++) begin
                src_sel = N'(s) << t;
                pulse(t, bit'(s));
                check("R2 selected sets pend", 32'(pend_flags), 32'(1 << t));
                check("R3 first no ovf", 32'(ovf_flags), 0);
                pulse(t, bit'(1 - s));
                check("R2 unselected ignored pend", 32'(pend_flags), 32'(1 << t));
                check("R2 unselected ignored ovf", 32'(ovf_flags), 0);
                pulse(t, bit'(s));
                check("R3 repeat sets ovf", 32'(ovf_flags), 32'(1 << t));
                check("R3 pend kept", 32'(pend_flags), 32'(1 << t));
                host_write(1, N'(1 << t));
                check("R8 clr pend", 32'(pend_flags), 0);
                check("R8 ovf untouched by pend clr", 32'(ovf_flags), 32'(1 << t));
                host_write(2, N'(1 << t));
                check("R8 clr ovf", 32'(ovf_flags), 0);
            end
        end
        src_sel = '0;

        // R8 set wins over clear
        host_wdata = 8'h04; sw_clr_pend_we = 1'b1; conv_irq[2] = 1'b1;
        tick();
        sw_clr_pend_we = 1'b0; conv_irq = '0;
        check("R8 set wins pend", 32'(pend_flags), 32'h04);
        host_wdata = 8'h04; sw_clr_ovf_we = 1'b1; conv_irq[2] = 1'b1;
        tick();
        sw_clr_ovf_we = 1'b0; conv_irq = '0;
        check("R8 set wins ovf", 32'(ovf_flags), 32'h04);
        host_write(1, 8'hFF); host_write(2, 8'hFF);

        // R4 force sweep, never overflow
        for (int m = 1; m < 256; m++) begin
            host_write(0, N'(m));
            check("R4 force pend", 32'(pend_flags), 32'(m));
            host_write(0, N'(m));
            check("R4 force no ovf", 32'(ovf_flags), 0);
            host_write(1, N'(m));
            check("R4 cleared", 32'(pend_flags), 0);
        end

        // R1 / R5 / R7 priority sweep over all pending patterns
        for (int m = 1; m < 256; m++) begin
            logic [N-1:0] rem;
            rem = N'(m);
            task_en = '0;
            host_write(0, N'(m));
            task_en = 8'hFF;
            while (rem != '0) begin
                int l;
                l = lowest(rem);
                tick();
                check("R5 start stb", 32'(start_stb), 1);
                check("R1 start pc", 32'(start_pc), 32'(vexp(l)));
                check("R1 run bit", 32'(run_map), 32'(1 << l));
                rem[l] = 1'b0;
                check("R5 pend cleared", 32'(pend_flags), 32'(rem));
                stop_task();
                check("R7 done pulse", 32'(done_irq), 32'(1 << l));
                check("R7 run cleared", 32'(run_map), 0);
                check("R5 stb one cycle", 32'(start_stb), 0);
            end
            tick();
            check("R7 done one cycle", 32'(done_irq), 0);
            check("R1 idle at end", 32'(start_stb), 0);
        end

        // R5 latency from a hardware pulse
        task_en = 8'hFF;
        pulse(4, 1'b0);
        check("R5 pend after pulse", 32'(pend_flags), 32'h10);
        check("R5 no start yet", 32'(start_stb), 0);
        tick();
        check("R5 start two cycles", 32'(start_stb), 1);
        check("R5 pc", 32'(start_pc), 32'(vexp(4)));
        check("R5 pend cleared", 32'(pend_flags), 0);
        stop_task();
        tick();

        // R6 no preemption
        host_write(0, 8'h40);
        tick();
        check("R6 running low", 32'(run_map), 32'h40);
        host_write(0, 8'h01);
        tick(); tick();
        check("R6 not preempted", 32'(run_map), 32'h40);
        check("R6 no new start", 32'(start_stb), 0);
        check("R6 high pending", 32'(pend_flags), 32'h01);
        stop_task();
        check("R7 done task7", 32'(done_irq), 32'h40);
        tick();
        check("R7 next start", 32'(start_stb), 1);
        check("R6 high dispatched", 32'(start_pc), 32'(vexp(0)));
        stop_task();
        tick();

        // R9 disabled tasks keep pending
        task_en = 8'h00;
        host_write(0, 8'h10);
        repeat (5) tick();
        check("R9 kept pending", 32'(pend_flags), 32'h10);
        check("R9 not run", 32'(run_map), 0);
        task_en = 8'h10;
        tick();
        check("R9 dispatched when enabled", 32'(start_pc), 32'(vexp(4)));
        check("R9 stb", 32'(start_stb), 1);
        stop_task();
        tick();
        task_en = 8'h02;
        host_write(0, 8'h03);
        tick();
        check("R9 enabled lower runs", 32'(run_map), 32'h02);
        check("R9 disabled higher waits", 32'(pend_flags), 32'h01);
        stop_task();
        task_en = 8'h00;
        host_write(1, 8'hFF);

        // R11 stop while idle
        stop_task();
        check("R11 no done", 32'(done_irq), 0);
        check("R11 run idle", 32'(run_map), 0);
        check("R11 pend unchanged", 32'(pend_flags), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule